// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns a software-generated interrupt request raised by one CPU into pending bits for the CPUs it targets. Each request carries the source CPU number, a 4-bit interrupt ID, a 2-bit target filter and a CPU target list with one bit per CPU. The block decodes the filter against the live enable state of each CPU interface and sets bits in a pending store. The store is organised as one word per interrupt ID, with one bit for each (source, target) pair.

A CPU interface counts as enabled when either of its two group-enable bits is set. Its other control bits have no influence. Disabled targets are skipped without any trace: nothing is held back for them, so enabling them later does not make a skipped request appear. A combinational read port returns, for one target and one ID, the bitmap of source CPUs that have that interrupt pending. A clear port removes exactly one (ID, source, target) bit. Arbitration and delivery to the processor lie outside the block.

The request path is a two-state machine. ST_IDLE means no captured request is waiting. ST_DELIVER means a request captured at the previous edge is applied to the store at this edge. The transitions are:
- IDLE→DELIVER on a valid request.
- DELIVER→DELIVER on a back-to-back request.
- DELIVER→IDLE when no request arrives.
- IDLE→IDLE otherwise.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset every pending bit is zero, so the read port returns 0 for every target and ID.
- R2: Filter 0 (list mode) marks pending every CPU whose bit is set in the target list and whose interface is enabled.
- R3: Filter 1 (others mode) marks pending every enabled CPU except the requester, and ignores the target list.
- R4: Filter 2 (self mode) marks pending only the requesting CPU, and only if its interface is enabled. The target list is ignored.
- R5: Filter 3 is reserved: a request with it changes no pending bit.
- R6: A target whose interface is disabled gets no pending bit. Enabling it afterwards does not make the skipped request appear.
- R7: CPU c owns bits [4c+3:4c] of cpu_ctl. It is enabled when bit 4c (group 0) or bit 4c+1 (group 1) is 1. Bits 4c+2 and 4c+3 are ignored.
- R8: A delivered request sets bit (NCPU*source + target) of the word for its ID. rd_src_map bit s returns that bit for source s, at the target rd_tgt and the ID rd_id.
- R9: A request sampled at clock edge k is applied at edge k+1 and is not yet visible between those edges. Requests on consecutive cycles are all applied.
- R10: Setting a bit that is already pending leaves it set and disturbs no other bit.
- R11: A clear resets exactly the one bit selected by clr_id, clr_src and clr_tgt at the same edge, and no other bit.
- R12: When a clear and a delivery hit the same bit at the same edge, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_src | input | 3 | Requesting CPU number |
| req_id | input | 4 | Interrupt ID |
| req_mode | input | 2 | Target filter (0 list, 1 others, 2 self, 3 reserved) |
| req_list | input | 8 | Target list, one bit per CPU |
| cpu_ctl | input | 32 | Per-CPU interface control, 4 bits per CPU |
| clr_valid | input | 1 | Clear strobe |
| clr_id | input | 4 | ID of bit to clear |
| clr_src | input | 3 | Source of bit to clear |
| clr_tgt | input | 3 | Target of bit to clear |
| rd_tgt | input | 3 | Read target CPU |
| rd_id | input | 4 | Read interrupt ID |
| rd_src_map | output | 8 | Pending sources for rd_tgt and rd_id |

## Verification
Some properties are checked on every cycle:
- The decoded target mask never includes a disabled CPU.
- The reserved filter yields an empty mask.
- The self filter yields at most one bit, which is the requester's.
- The others filter never includes the requester.
- Every request is applied on the following cycle.
- A clear empties its bit unless a coincident set wins.

The bench's scenarios cover what needs a reference over time:
- The exact bit placement seen through the read port.
- The accumulation and idempotence of repeated requests.
- The fact that a skipped target stays empty after it is enabled.
- The full sweep over filters, sources, lists and enable patterns, compared against an arithmetic model.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
    typedef enum logic [1:0] {
        FLT_LIST   = 2'd0,
        FLT_OTHERS = 2'd1,
        FLT_SELF   = 2'd2,
        FLT_RSVD   = 2'd3
    } flt_mode_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_DELIVER = 1'b1
    } dsp_state_e;
endpackage

// File: rtl/sgi_dispatch_fsm.sv
module sgi_dispatch_fsm import sgi_pkg::*; #(
    parameter int NCPU = 8,
    parameter int NSGI = 16,
    localparam int SW = $clog2(NCPU),
    localparam int IW = $clog2(NSGI)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [SW-1:0]   req_src,
    input  logic [IW-1:0]   req_id,
    input  logic [1:0]      req_mode,
    input  logic [NCPU-1:0] req_list,
    output logic            dlv_valid,
    output logic [SW-1:0]   dlv_src,
    output logic [IW-1:0]   dlv_id,
    output flt_mode_e       dlv_mode,
    output logic [NCPU-1:0] dlv_list
);
    dsp_state_e state_q, state_d;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = req_valid ? ST_DELIVER : ST_IDLE;
            ST_DELIVER: state_d = req_valid ? ST_DELIVER : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured request fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlv_src  <= '0;
            dlv_id   <= '0;
            dlv_mode <= FLT_RSVD;
            dlv_list <= '0;
        end else if (req_valid) begin
            dlv_src  <= req_src;
            dlv_id   <= req_id;
            dlv_mode <= flt_mode_e'(req_mode);
            dlv_list <= req_list;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_DELIVER: dlv_valid = 1'b1;
            default:    dlv_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/sgi_target_decode.sv
module sgi_target_decode import sgi_pkg::*; #(
    parameter int NCPU  = 8,
    parameter int CTL_W = 4,
    localparam int SW = $clog2(NCPU)
) (
    input  flt_mode_e             mode,
    input  logic [SW-1:0]         src,
    input  logic [NCPU-1:0]       list,
    input  logic [NCPU*CTL_W-1:0] cpu_ctl,
    output logic [NCPU-1:0]       en_vec,
    output logic [NCPU-1:0]       tgt_mask
);
    logic [NCPU-1:0] self_bit;

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        // only the two group-enable bits count
        assign en_vec[c]   = cpu_ctl[c*CTL_W] | cpu_ctl[c*CTL_W+1];
        assign self_bit[c] = (src == SW'(c));
    end

    always_comb begin
        unique case (mode)
            FLT_LIST:   tgt_mask = list & en_vec;
            FLT_OTHERS: tgt_mask = en_vec & ~self_bit;
            FLT_SELF:   tgt_mask = en_vec & self_bit;
            default:    tgt_mask = '0;
        endcase
    end
endmodule

// File: rtl/sgi_pend_store.sv
module sgi_pend_store #(
    parameter int NCPU = 8,
    parameter int NSGI = 16,
    localparam int SW = $clog2(NCPU),
    localparam int IW = $clog2(NSGI),
    localparam int PW = NCPU * NCPU
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_valid,
    input  logic [IW-1:0]   set_id,
    input  logic [SW-1:0]   set_src,
    input  logic [NCPU-1:0] set_mask,
    input  logic            clr_valid,
    input  logic [IW-1:0]   clr_id,
    input  logic [SW-1:0]   clr_src,
    input  logic [SW-1:0]   clr_tgt,
    input  logic [SW-1:0]   rd_tgt,
    input  logic [IW-1:0]   rd_id,
    output logic [NCPU-1:0] rd_src_map,
    output logic [PW-1:0]   pend [NSGI]
);
    for (genvar g = 0; g < NSGI; g++) begin : g_word
        logic [PW-1:0] set_m, clr_m;
        always_comb begin
            for (int s = 0; s < NCPU; s++) begin
                for (int t = 0; t < NCPU; t++) begin
                    set_m[s*NCPU+t] = set_valid && (set_id == IW'(g)) &&
                                      (set_src == SW'(s)) && set_mask[t];
                    clr_m[s*NCPU+t] = clr_valid && (clr_id == IW'(g)) &&
                                      (clr_src == SW'(s)) && (clr_tgt == SW'(t));
                end
            end
        end
        // set is applied after clear, so set wins on a collision
        always_ff @(posedge clk) begin
            if (!rst_n) pend[g] <= '0;
            else        pend[g] <= (pend[g] & ~clr_m) | set_m;
        end
    end

    always_comb begin
        for (int s = 0; s < NCPU; s++) begin
            rd_src_map[s] = 1'b0;
            for (int t = 0; t < NCPU; t++)
                if (rd_tgt == SW'(t)) rd_src_map[s] = pend[rd_id][s*NCPU+t];
        end
    end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch import sgi_pkg::*; #(
    parameter int NCPU  = 8,
    parameter int NSGI  = 16,
    parameter int CTL_W = 4,
    localparam int SW = $clog2(NCPU),
    localparam int IW = $clog2(NSGI),
    localparam int PW = NCPU * NCPU
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [SW-1:0]         req_src,
    input  logic [IW-1:0]         req_id,
    input  logic [1:0]            req_mode,
    input  logic [NCPU-1:0]       req_list,
    input  logic [NCPU*CTL_W-1:0] cpu_ctl,
    input  logic                  clr_valid,
    input  logic [IW-1:0]         clr_id,
    input  logic [SW-1:0]         clr_src,
    input  logic [SW-1:0]         clr_tgt,
    input  logic [SW-1:0]         rd_tgt,
    input  logic [IW-1:0]         rd_id,
    output logic [NCPU-1:0]       rd_src_map
);
    logic            dlv_valid;
    logic [SW-1:0]   dlv_src;
    logic [IW-1:0]   dlv_id;
    flt_mode_e       dlv_mode;
    logic [NCPU-1:0] dlv_list;
    logic [NCPU-1:0] en_vec;
    logic [NCPU-1:0] tgt_mask;
    logic [PW-1:0]   pend [NSGI];

    sgi_dispatch_fsm #(.NCPU(NCPU), .NSGI(NSGI)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_src(req_src), .req_id(req_id),
        .req_mode(req_mode), .req_list(req_list),
        .dlv_valid(dlv_valid), .dlv_src(dlv_src), .dlv_id(dlv_id),
        .dlv_mode(dlv_mode), .dlv_list(dlv_list)
    );

    sgi_target_decode #(.NCPU(NCPU), .CTL_W(CTL_W)) u_dec (
        .mode(dlv_mode), .src(dlv_src), .list(dlv_list), .cpu_ctl(cpu_ctl),
        .en_vec(en_vec), .tgt_mask(tgt_mask)
    );

    sgi_pend_store #(.NCPU(NCPU), .NSGI(NSGI)) u_store (
        .clk(clk), .rst_n(rst_n),
        .set_valid(dlv_valid), .set_id(dlv_id), .set_src(dlv_src),
        .set_mask(tgt_mask),
        .clr_valid(clr_valid), .clr_id(clr_id), .clr_src(clr_src),
        .clr_tgt(clr_tgt),
        .rd_tgt(rd_tgt), .rd_id(rd_id), .rd_src_map(rd_src_map),
        .pend(pend)
    );
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
    parameter int NCPU = 8,
    parameter int NSGI = 16,
    localparam int SW  = $clog2(NCPU),
    localparam int IW  = $clog2(NSGI),
    localparam int PW  = NCPU * NCPU,
    localparam int PIW = $clog2(PW)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            dlv_valid,
    input logic [SW-1:0]   dlv_src,
    input logic [IW-1:0]   dlv_id,
    input logic [1:0]      dlv_mode,
    input logic [NCPU-1:0] en_vec,
    input logic [NCPU-1:0] tgt_mask,
    input logic            clr_valid,
    input logic [IW-1:0]   clr_id,
    input logic [SW-1:0]   clr_src,
    input logic [SW-1:0]   clr_tgt,
    input logic [PW-1:0]   pend [NSGI]
);
    logic [PIW-1:0] cidx, cidx_q;
    logic [IW-1:0]  cid_q;
    logic           set_hit;

    assign cidx    = PIW'(clr_src) * PIW'(NCPU) + PIW'(clr_tgt);
    assign set_hit = dlv_valid && (dlv_id == clr_id) && (dlv_src == clr_src) &&
                     tgt_mask[clr_tgt];

    always_ff @(posedge clk) begin
        cidx_q <= cidx;
        cid_q  <= clr_id;
    end

    p_deliver_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dlv_valid);
    p_mask_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> ((tgt_mask & ~en_vec) == '0));
    p_reserved_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_mode == 2'd3) |-> (tgt_mask == '0));
    p_self_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_mode == 2'd2) |->
            ($countones(tgt_mask) <= 1 && (tgt_mask & ~(NCPU'(1) << dlv_src)) == '0));
    p_others_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_mode == 2'd1) |-> !tgt_mask[dlv_src]);
    p_clear_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && !set_hit) |=> !pend[cid_q][cidx_q]);
    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && set_hit) |=> pend[cid_q][cidx_q]);
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NCPU(NCPU), .NSGI(NSGI)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .dlv_valid(dlv_valid), .dlv_src(dlv_src), .dlv_id(dlv_id),
    .dlv_mode(dlv_mode), .en_vec(en_vec), .tgt_mask(tgt_mask),
    .clr_valid(clr_valid), .clr_id(clr_id), .clr_src(clr_src),
    .clr_tgt(clr_tgt), .pend(pend)
);

// File: tb/sgi_dispatch_bench.sv
module sgi_dispatch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_src = '0;
    logic [3:0]  req_id = '0;
    logic [1:0]  req_mode = '0;
    logic [7:0]  req_list = '0;
    logic [31:0] cpu_ctl = '0;
    logic        clr_valid = 1'b0;
    logic [3:0]  clr_id = '0;
    logic [2:0]  clr_src = '0;
    logic [2:0]  clr_tgt = '0;
    logic [2:0]  rd_tgt = '0;
    logic [3:0]  rd_id = '0;
    logic [7:0]  rd_src_map;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [7:0] exp_map [16][8];   // [id][target] -> source bitmap

    always #5 clk = ~clk;

    sgi_dispatch u_sgi_dispatch (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
        .req_id(req_id), .req_mode(req_mode), .req_list(req_list),
        .cpu_ctl(cpu_ctl), .clr_valid(clr_valid), .clr_id(clr_id),
        .clr_src(clr_src), .clr_tgt(clr_tgt), .rd_tgt(rd_tgt),
        .rd_id(rd_id), .rd_src_map(rd_src_map)
    );

    // enabled CPUs alternate group 0 / group 1; disabled ones carry only ignored bits
    function automatic logic [31:0] make_ctl(input logic [7:0] en);
        logic [31:0] v = '0;
        for (int c = 0; c < 8; c++)
            v[c*4 +: 4] = en[c] ? ((c % 2 == 0) ? 4'b0001 : 4'b0010)
                                : ((c % 2 == 0) ? 4'b1000 : 4'b0100);
        return v;
    endfunction

    function automatic logic [7:0] ctl_en(input logic [31:0] v);
        logic [7:0] e;
        for (int c = 0; c < 8; c++) e[c] = v[c*4] | v[c*4+1];
        return e;
    endfunction

    function automatic logic [7:0] exp_mask(input int mode, input int src,
                                            input logic [7:0] list, input logic [7:0] en);
        case (mode)
            0: return list & en;
            1: return en & ~(8'd1 << src);
            2: return en & (8'd1 << src);
            default: return 8'd0;
        endcase
    endfunction

    function automatic void model_set(input int mode, input int src, input int id,
                                      input logic [7:0] list, input logic [7:0] en);
        logic [7:0] m = exp_mask(mode, src, list, en);
        for (int t = 0; t < 8; t++) if (m[t]) exp_map[id][t][src] = 1'b1;
    endfunction

    task automatic check_id(input int id, input string tag);
        bit bad = 1'b0;
        n_tests++;
        for (int t = 0; t < 8; t++) begin
            rd_id = 4'(id); rd_tgt = 3'(t);
            #1;
            if (!bad && rd_src_map !== exp_map[id][t]) begin
                bad = 1'b1;
                n_fail++;
                $display("FAIL %s id=%0d tgt=%0d actual=%h expected=%h",
                         tag, id, t, rd_src_map, exp_map[id][t]);
            end
        end
    endtask

    task automatic check_val(input logic [7:0] act, input logic [7:0] expv, input string tag);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic send(input int mode, input int src, input int id, input logic [7:0] list);
        @(negedge clk);
        req_valid = 1'b1; req_mode = 2'(mode); req_src = 3'(src);
        req_id = 4'(id); req_list = list;
        @(negedge clk);
        req_valid = 1'b0;
        model_set(mode, src, id, list, ctl_en(cpu_ctl));
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) for (int t = 0; t < 8; t++) exp_map[i][t] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: everything empty after reset
        for (int i = 0; i < 16; i++) check_id(i, "R1");

        cpu_ctl = make_ctl(8'hFF);
        // R9: not visible between capture and apply, visible after
        @(negedge clk);
        req_valid = 1'b1; req_mode = 2'd2; req_src = 3'd3; req_id = 4'd5; req_list = 8'h00;
        @(negedge clk);
        req_valid = 1'b0;
        rd_id = 4'd5; rd_tgt = 3'd3; #1;
        check_val(rd_src_map, 8'h00, "R9 before apply");
        @(negedge clk);
        model_set(2, 3, 5, 8'h00, 8'hFF);
        rd_id = 4'd5; rd_tgt = 3'd3; #1;
        check_val(rd_src_map, 8'h08, "R8 source bit position");
        check_id(5, "R4 self");

        // R9: back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; req_mode = 2'd0; req_src = 3'd1; req_id = 4'd6; req_list = 8'h81;
        @(negedge clk);
        req_mode = 2'd0; req_src = 3'd2; req_id = 4'd7; req_list = 8'h18;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        model_set(0, 1, 6, 8'h81, 8'hFF);
        model_set(0, 2, 7, 8'h18, 8'hFF);
        check_id(6, "R9 back-to-back first");
        check_id(7, "R9 back-to-back second");

        // R6: disabled target skipped and not queued
        cpu_ctl = make_ctl(8'hDF);
        send(0, 0, 9, 8'hFF);
        check_id(9, "R6 skip");
        cpu_ctl = make_ctl(8'hFF);
        repeat (3) @(negedge clk);
        rd_id = 4'd9; rd_tgt = 3'd5; #1;
        check_val(rd_src_map, 8'h00, "R6 not queued");

        // R7: only the two group-enable bits decide
        cpu_ctl = make_ctl(8'hFF);
        cpu_ctl[2*4 +: 4] = 4'b1100;
        send(2, 2, 10, 8'h00);
        rd_id = 4'd10; rd_tgt = 3'd2; #1;
        check_val(rd_src_map, 8'h00, "R7 upper bits ignored");
        cpu_ctl[2*4 +: 4] = 4'b0010;
        send(2, 2, 10, 8'h00);
        rd_id = 4'd10; rd_tgt = 3'd2; #1;
        check_val(rd_src_map, 8'h04, "R7 group1 alone enables");
        cpu_ctl = make_ctl(8'hFF);

        // R10: repeat of a pending request is idempotent
        send(0, 1, 6, 8'h81);
        check_id(6, "R10 idempotent");

        // R11: clear one bit only
        send(1, 4, 11, 8'h00);
        @(negedge clk);
        clr_valid = 1'b1; clr_id = 4'd11; clr_src = 3'd4; clr_tgt = 3'd6;
        @(negedge clk);
        clr_valid = 1'b0;
        exp_map[11][6][4] = 1'b0;
        check_id(11, "R11 single clear");

        // R12: coincident set and clear of the same bit
        @(negedge clk);
        req_valid = 1'b1; req_mode = 2'd2; req_src = 3'd0; req_id = 4'd12; req_list = 8'h00;
        @(negedge clk);
        req_valid = 1'b0;
        clr_valid = 1'b1; clr_id = 4'd12; clr_src = 3'd0; clr_tgt = 3'd0;
        @(negedge clk);
        clr_valid = 1'b0;
        model_set(2, 0, 12, 8'h00, 8'hFF);
        check_id(12, "R12 set wins");

        // R5: reserved filter with everything enabled and a full list
        send(3, 5, 13, 8'hFF);
        check_id(13, "R5 reserved");

        // sweep: filters x sources x list/enable patterns
        for (int mode = 0; mode < 4; mode++) begin
            for (int src = 0; src < 8; src++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [7:0] lst;
                    logic [7:0] en;
                    int id;
                    lst = (k == 0) ? 8'hFF : (k == 1) ? 8'h5A : (8'd1 << ((src + 3) % 8));
                    en  = (k == 0) ? 8'hFF : (k == 1) ? 8'hB7 : 8'h3C;
                    id  = (mode * 3 + k + src) % 16;
                    cpu_ctl = make_ctl(en);
                    send(mode, src, id, lst);
                    case (mode)
                        0: check_id(id, "R2 list sweep");
                        1: check_id(id, "R3 others sweep");
                        2: check_id(id, "R4 self sweep");
                        default: check_id(id, "R5 reserved sweep");
                    endcase
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule